// File: doc/BRIEF.md
# Two-Wire Register Port Slave

This block is the slave end of a half-duplex serial register port: one serial clock input from the host and one shared data line that the host and the slave take turns driving. Both host lines are resynchronised into the local clock domain, and the slave acts on the edges it detects there. Every transaction begins with a direction bit, followed by a 7-bit register address, then one data byte. On a write the host supplies the byte. On a read the slave takes the line as soon as the address is complete and shifts the byte out. Behind the port sits a small register file whose entry 0 is a fixed identity value.

The framing counter advances on every rising edge it sees. A stray rising edge, such as one at power-up before the host has settled its lines, therefore shifts all later bits by one position. Framing recovers in two ways: a synchronous resync input, or an idle timeout that fires when the serial clock stops toggling in the middle of a frame.

The frame controller has four states. `ST_DIR` waits for the direction bit. `ST_ADDR` collects address bits. `ST_WDATA` collects write data. `ST_RDATA` drives read data. The transitions are:
- `ST_DIR`→`ST_ADDR` on any sampled bit.
- `ST_ADDR`→`ST_WDATA` after the last address bit of a write.
- `ST_ADDR`→`ST_RDATA` after the last address bit of a read.
- `ST_WDATA`→`ST_DIR` after the eighth data bit, at which point the byte is stored.
- `ST_RDATA`→`ST_DIR` after the eighth read rising edge.
- Any state→`ST_DIR` on resync or idle timeout.

Top module: `serial_reg_slave`

## Requirements
- R1: Each detected rising edge of `sclk_in` samples `sdio_in` as the next bit. The first bit of a frame selects the direction: 0 is a read, 1 is a write.
- R2: The seven bits after the direction bit form the register address, most significant bit first.
- R3: On a write, the next eight bits (MSB first) are stored at the addressed entry of an 8-entry, 8-bit file. Entries 1 to 7 reset to 0x00.
- R4: On a read, `sdio_oe` goes high and the MSB of the addressed byte appears on `sdio_out` after the rising edge of the last address bit, before the next falling edge.
- R5: The read byte is presented MSB first. Each later bit changes only after a falling edge of `sclk_in`, so the host samples it on the following rising edge.
- R6: Address 0x00 always reads 0x03, and writes to it are ignored.
- R7: Addresses 0x08 to 0x7F read as 0x00, and writes to them change no entry.
- R8: After the eighth rising edge of read data, `sdio_oe` drops and the next sampled bit is taken as a new direction bit.
- R9: A stray rising edge before a host frame is taken as a direction bit. With a low line this is a read: the slave then uses the host's first seven bits as the address (the intended address shifted right by one) and drives the line after the host's seventh bit.
- R10: `resync` high for one clock returns the controller to `ST_DIR` and releases the line within a few clocks. The next frame is then framed correctly.
- R11: If no edge of `sclk_in` is seen for `IDLE_TIMEOUT` clocks while a frame is in progress, the controller returns to `ST_DIR` and releases the line.
- R12: After reset, and whenever the slave is not driving, `sdio_oe` and `sdio_out` are 0. Write frames never enable the driver.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local clock that samples the serial lines |
| rst_n | input | 1 | Asynchronous active-low reset |
| resync | input | 1 | Synchronous framing reset, active high |
| sclk_in | input | 1 | Serial clock from the host |
| sdio_in | input | 1 | Data line as seen from the pad |
| sdio_out | output | 1 | Data value driven by the slave |
| sdio_oe | output | 1 | Output enable for the shared data line |

## Verification
The bench keeps the default 7-bit address and 8-entry file, so every one of the 128 addresses can be written and read back in a single run. It sets `IDLE_TIMEOUT` to 40 clocks against a serial half period of 8 clocks. That value never fires during a normal frame, yet a deliberately stalled frame expires within a few dozen cycles. Two synchroniser stages keep the edge-to-output latency well inside one half period, so the turnaround and release points can be sampled at fixed places in each bit.

// File: rtl/srs_pkg.sv
package srs_pkg;
    typedef enum logic [1:0] {
        ST_DIR   = 2'd0,
        ST_ADDR  = 2'd1,
        ST_WDATA = 2'd2,
        ST_RDATA = 2'd3
    } frame_state_t;
endpackage

// File: rtl/srs_edge_sync.sv
module srs_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sclk_in,
    input  logic sdio_in,
    output logic bit_rise,
    output logic bit_fall,
    output logic bit_val
);
    localparam int LAST = STAGES - 1;

    logic [STAGES-1:0] sclk_q;
    logic [STAGES-1:0] sdio_q;
    logic              sclk_prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sclk_q      <= '0;
            sdio_q      <= '0;
            sclk_prev_q <= 1'b0;
        end else begin
            sclk_q[0] <= sclk_in;
            sdio_q[0] <= sdio_in;
            for (int i = 1; i < STAGES; i++) begin
                sclk_q[i] <= sclk_q[i-1];
                sdio_q[i] <= sdio_q[i-1];
            end
            sclk_prev_q <= sclk_q[LAST];
        end
    end

    assign bit_rise = sclk_q[LAST] & ~sclk_prev_q;
    assign bit_fall = ~sclk_q[LAST] & sclk_prev_q;
    assign bit_val  = sdio_q[LAST];

    // R1: each host edge yields a single sampling pulse
    assert_single_pulse_R1: assert property (@(posedge clk) disable iff (!rst_n)
        bit_rise |=> !bit_rise);
endmodule

// File: rtl/srs_regfile.sv
module srs_regfile #(
    parameter int              ADDR_W   = 7,
    parameter int              DATA_W   = 8,
    parameter int              NUM_REGS = 8,
    parameter logic [DATA_W-1:0] ID_VALUE = 8'h03
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] rd_data
);
    localparam int                IDX_W    = $clog2(NUM_REGS);
    localparam logic [ADDR_W-1:0] ADDR_END = ADDR_W'(NUM_REGS);

    logic [DATA_W-1:0] store_q [NUM_REGS];
    logic              in_range;
    logic              wr_hit;

    assign in_range = reg_addr < ADDR_END;
    assign wr_hit   = wr_en && in_range && (reg_addr != '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_REGS; i++) store_q[i] <= '0;
        end else if (wr_hit) begin
            store_q[reg_addr[IDX_W-1:0]] <= wr_data;
        end
    end

    always_comb begin
        if (reg_addr == '0)   rd_data = ID_VALUE;
        else if (in_range)    rd_data = store_q[reg_addr[IDX_W-1:0]];
        else                  rd_data = '0;
    end

    // R3: a write to a writable entry is visible on the read path next cycle
    assert_store_lands_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && reg_addr != '0 && reg_addr < ADDR_END)
        |=> (reg_addr != $past(reg_addr)) || (rd_data == $past(wr_data)));
endmodule

// File: rtl/srs_frame_fsm.sv
module srs_frame_fsm
    import srs_pkg::*;
#(
    parameter int ADDR_W       = 7,
    parameter int DATA_W       = 8,
    parameter int IDLE_TIMEOUT = 1024
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              resync,
    input  logic              bit_rise,
    input  logic              bit_fall,
    input  logic              bit_val,
    input  logic [DATA_W-1:0] rd_data,
    output logic [ADDR_W-1:0] reg_addr,
    output logic              wr_en,
    output logic [DATA_W-1:0] wr_data,
    output logic              drive_en,
    output logic              drive_bit
);
    localparam int FIELD_MAX = (ADDR_W > DATA_W) ? ADDR_W : DATA_W;
    localparam int CNT_W     = $clog2(FIELD_MAX);
    localparam int IDLE_W    = $clog2(IDLE_TIMEOUT + 1);
    localparam logic [CNT_W-1:0]  ADDR_LAST = CNT_W'(ADDR_W - 1);
    localparam logic [CNT_W-1:0]  DATA_LAST = CNT_W'(DATA_W - 1);
    localparam logic [IDLE_W-1:0] IDLE_LAST = IDLE_W'(IDLE_TIMEOUT - 1);

    frame_state_t      state_q, state_d;
    logic [CNT_W-1:0]  cnt_q;
    logic              dir_write_q;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] shift_q;
    logic              primed_q;
    logic              first_fall_q;
    logic [IDLE_W-1:0] idle_q;
    logic              timeout;

    assign timeout = (state_q != ST_DIR) && !bit_rise && !bit_fall && (idle_q == IDLE_LAST);

    // next-state logic
    always_comb begin
        state_d = state_q;
        if (resync || timeout) begin
            state_d = ST_DIR;
        end else if (bit_rise) begin
            unique case (state_q)
                ST_DIR:   state_d = ST_ADDR;
                ST_ADDR:  if (cnt_q == ADDR_LAST) state_d = dir_write_q ? ST_WDATA : ST_RDATA;
                ST_WDATA: if (cnt_q == DATA_LAST) state_d = ST_DIR;
                ST_RDATA: if (cnt_q == DATA_LAST) state_d = ST_DIR;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_DIR;
        else        state_q <= state_d;
    end

    // framing datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q        <= '0;
            dir_write_q  <= 1'b0;
            addr_q       <= '0;
            shift_q      <= '0;
            primed_q     <= 1'b0;
            first_fall_q <= 1'b0;
            idle_q       <= '0;
        end else begin
            idle_q <= (state_d == ST_DIR || bit_rise || bit_fall) ? '0 : idle_q + 1'b1;

            if (state_d != state_q) cnt_q <= '0;
            else if (bit_rise)      cnt_q <= cnt_q + 1'b1;

            if (bit_rise && !resync) begin
                unique case (state_q)
                    ST_DIR:   dir_write_q <= bit_val;
                    ST_ADDR:  addr_q      <= {addr_q[ADDR_W-2:0], bit_val};
                    ST_WDATA: shift_q     <= {shift_q[DATA_W-2:0], bit_val};
                    ST_RDATA: ;
                endcase
            end

            if (state_d == ST_RDATA && state_q != ST_RDATA) begin
                primed_q     <= 1'b0;
                first_fall_q <= 1'b1;
            end else if (state_q == ST_RDATA) begin
                if (!primed_q) begin
                    shift_q  <= rd_data;
                    primed_q <= 1'b1;
                end
                if (bit_fall) begin
                    if (first_fall_q)  first_fall_q <= 1'b0;
                    else if (primed_q) shift_q      <= {shift_q[DATA_W-2:0], 1'b0};
                end
            end
        end
    end

    // outputs
    always_comb begin
        reg_addr  = addr_q;
        wr_en     = bit_rise && !resync && (state_q == ST_WDATA) && (cnt_q == DATA_LAST);
        wr_data   = {shift_q[DATA_W-2:0], bit_val};
        drive_en  = (state_q == ST_RDATA) && primed_q;
        drive_bit = shift_q[DATA_W-1];
    end

    // R4: a completed read address turns the line around two cycles later
    assert_turnaround_R4: assert property (@(posedge clk) disable iff (!rst_n || resync)
        (state_q == ST_ADDR && bit_rise && cnt_q == ADDR_LAST && !dir_write_q)
        |=> ##1 drive_en);
    // R5: while driving, the data bit only moves right after a falling edge
    assert_bit_holds_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (drive_en && $past(drive_en) && !$past(bit_fall)) |-> $stable(drive_bit));
    // R8: the eighth read rising edge ends the drive
    assert_release_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (drive_en && bit_rise && cnt_q == DATA_LAST) |=> !drive_en);
    // R10: resync always frees the line
    assert_resync_frees_R10: assert property (@(posedge clk) disable iff (!rst_n)
        resync |=> !drive_en);
    // R11: the idle counter never passes its limit
    assert_idle_bound_R11: assert property (@(posedge clk) disable iff (!rst_n)
        idle_q <= IDLE_LAST);
endmodule

// File: rtl/serial_reg_slave.sv
module serial_reg_slave #(
    parameter int              ADDR_W       = 7,
    parameter int              DATA_W       = 8,
    parameter int              NUM_REGS     = 8,
    parameter logic [DATA_W-1:0] ID_VALUE   = 8'h03,
    parameter int              SYNC_STAGES  = 2,
    parameter int              IDLE_TIMEOUT = 1024
) (
    input  logic clk,
    input  logic rst_n,
    input  logic resync,
    input  logic sclk_in,
    input  logic sdio_in,
    output logic sdio_out,
    output logic sdio_oe
);
    logic              bit_rise, bit_fall, bit_val;
    logic [ADDR_W-1:0] reg_addr;
    logic              wr_en;
    logic [DATA_W-1:0] wr_data, rd_data;
    logic              drive_en, drive_bit;

    srs_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .sclk_in(sclk_in), .sdio_in(sdio_in),
        .bit_rise(bit_rise), .bit_fall(bit_fall), .bit_val(bit_val)
    );

    srs_frame_fsm #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .IDLE_TIMEOUT(IDLE_TIMEOUT)) u_fsm (
        .clk(clk), .rst_n(rst_n), .resync(resync),
        .bit_rise(bit_rise), .bit_fall(bit_fall), .bit_val(bit_val),
        .rd_data(rd_data), .reg_addr(reg_addr), .wr_en(wr_en), .wr_data(wr_data),
        .drive_en(drive_en), .drive_bit(drive_bit)
    );

    srs_regfile #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_REGS(NUM_REGS), .ID_VALUE(ID_VALUE)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .reg_addr(reg_addr),
        .wr_data(wr_data), .rd_data(rd_data)
    );

    assign sdio_oe  = drive_en;
    assign sdio_out = drive_en & drive_bit;

    // R12: nothing appears on the data output unless the driver is enabled
    assert_quiet_when_off_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !sdio_oe |-> !sdio_out);
endmodule

// File: tb/sim_serial_reg_slave.sv
module sim_serial_reg_slave;
    localparam int HALF = 8;
    localparam int TMO  = 40;

    logic clk = 1'b0, rst_n = 1'b0, resync = 1'b0, sclk = 1'b0, sdio = 1'b0;
    logic sdio_out, sdio_oe;
    int n_chk = 0, n_fail = 0;

    always #10 clk = ~clk;

    serial_reg_slave #(.IDLE_TIMEOUT(TMO)) u0 (
        .clk(clk), .rst_n(rst_n), .resync(resync), .sclk_in(sclk),
        .sdio_in(sdio), .sdio_out(sdio_out), .sdio_oe(sdio_oe)
    );

    function automatic logic [7:0] val(input int a);
        return 8'((a * 37 + 5) & 255);
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic clk_bit(input logic din, output logic dout, output logic oe);
        @(negedge clk);
        sclk = 1'b0;
        sdio = din;
        repeat (HALF) @(negedge clk);
        dout = sdio_out;
        oe   = sdio_oe;
        sclk = 1'b1;
        repeat (HALF) @(negedge clk);
    endtask

    task automatic send_bits(input logic [15:0] v, input int n, output bit drove);
        logic d, o;
        drove = 1'b0;
        for (int i = n - 1; i >= 0; i--) begin
            clk_bit(v[i], d, o);
            if (o || d) drove = 1'b1;
        end
    endtask

    task automatic write_reg(input logic [6:0] a, input logic [7:0] d, output bit drove);
        send_bits({1'b1, a, d}, 16, drove);
        drove = drove | sdio_oe;
    endtask

    task automatic read_reg(input logic [6:0] a, output logic [7:0] d,
                            output bit turn, output bit held, output bit rel);
        bit   dr;
        logic b, o;
        send_bits({8'h00, 1'b0, a}, 8, dr);
        turn = sdio_oe && !dr;
        held = 1'b1;
        d    = '0;
        for (int i = 0; i < 8; i++) begin
            clk_bit(1'b0, b, o);
            d = {d[6:0], b};
            if (!o) held = 1'b0;
        end
        rel = !sdio_oe && !sdio_out;
    endtask

    task automatic pulse_resync();
        @(negedge clk) resync = 1'b1;
        @(negedge clk) resync = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    task automatic read_check(input int a, input logic [7:0] exp, input string req);
        logic [7:0] d;
        bit t, h, r;
        read_reg(7'(a), d, t, h, r);
        chk(d == exp, req, d, exp);
        chk(t, "R4 turnaround", int'(t), 1);
        chk(h && r, "R8 drive window and release", int'({h, r}), 3);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual 0x0 expected 0x1");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        bit dr;
        logic d, o;
        logic [7:0] byte_rd;

        repeat (5) @(negedge clk);
        chk(!sdio_oe && !sdio_out, "R12 reset outputs", int'({sdio_oe, sdio_out}), 0);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);

        read_check(5, 8'h00, "R3 reset value");
        read_check(0, 8'h03, "R6 identity");

        // R1 / R3: write every writable entry, then read all back (R2, R5)
        for (int a = 1; a < 8; a++) begin
            write_reg(7'(a), val(a), dr);
            chk(!dr, "R12 write never drives", int'(dr), 0);
        end
        for (int a = 0; a < 8; a++)
            read_check(a, (a == 0) ? 8'h03 : val(a), "R2 R5 readback");

        write_reg(7'd0, 8'hAA, dr);
        read_check(0, 8'h03, "R6 identity write ignored");

        // R7: out-of-range addresses
        for (int a = 8; a < 128; a++) write_reg(7'(a), 8'(a) ^ 8'h5A, dr);
        for (int a = 1; a < 8; a++) read_check(a, val(a), "R7 in-range unchanged");
        for (int a = 8; a < 128; a++) read_check(a, 8'h00, "R7 out-of-range reads zero");

        // R9: stray rising edge with low data line, then host reads 0x05
        @(negedge clk) sclk = 1'b0; sdio = 1'b0;
        repeat (HALF) @(negedge clk);
        sclk = 1'b1;
        repeat (HALF) @(negedge clk);
        for (int i = 7; i >= 1; i--) clk_bit(8'h05 >> i, d, o);
        chk(sdio_oe, "R9 early drive", int'(sdio_oe), 1);
        byte_rd = '0;
        for (int i = 0; i < 8; i++) begin
            clk_bit(1'b1, d, o);
            byte_rd = {byte_rd[6:0], d};
        end
        chk(byte_rd == val(2), "R9 shifted address", byte_rd, val(2));
        pulse_resync();
        chk(!sdio_oe, "R10 released after resync", int'(sdio_oe), 0);
        read_check(5, val(5), "R10 framing restored");

        // R10: resync in the middle of a read
        send_bits({8'h00, 1'b0, 7'd6}, 8, dr);
        clk_bit(1'b0, d, o);
        chk(o, "R10 driving before resync", int'(o), 1);
        pulse_resync();
        chk(!sdio_oe, "R10 mid-read release", int'(sdio_oe), 0);
        read_check(6, val(6), "R10 next frame");

        // R11: stalled partial write, then stalled read
        send_bits({12'h000, 4'b1000}, 4, dr);
        repeat (TMO * 2) @(negedge clk);
        read_check(7, val(7), "R11 timeout after partial write");
        send_bits({8'h00, 1'b0, 7'd3}, 8, dr);
        chk(sdio_oe, "R11 driving before stall", int'(sdio_oe), 1);
        repeat (TMO * 2) @(negedge clk);
        chk(!sdio_oe, "R11 timeout release", int'(sdio_oe), 0);
        read_check(3, val(3), "R11 next frame");

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule